// File: doc/BRIEF.md
# Switched-Bus Address Datapath

This block is the register and bus datapath of a small word-oriented processor in which no dedicated incrementer or address adder exists. Eight working registers sit on two buses, an address bus and a data bus, and a single shared ALU is reached from those buses through steerable switches. Both the program-pointer increment and the formation of memory addresses are performed by routing values through that one ALU over several clock steps. Each step takes one clock.

A request to advance the program pointer walks a fixed sequence. The pointer is steered into the ALU and incremented. The sum is parked in an ALU result latch, the pointer is cleared, and it is then reloaded from the latch over the data bus. A request to form an address selects one register and either passes it straight through or adds the jump-base register to it. The result is captured in an address latch. Memory is then read at that address, and the word just read is written back to the same location, because a read destroys the stored word. The write-back is suppressed whenever the latched address falls in the read-only region of the memory map. A one-cycle done strobe closes every sequence.

Registers are loaded through a simple write port while the block is idle. A surrounding sequencer issues the requests. Every word and address is `W` bits wide, and all arithmetic wraps modulo 2^W.

Top module: `swbus_addr_path`

## Requirements
- R1: While reset is held and directly after it, `prog_ptr` is 0 and `busy`, `done`, `mem_rd` and `mem_wr` are all 0.
- R2: A `start_inc` seen at a clock edge while idle is accepted. From the third edge after that, `prog_ptr` equals the old value plus 1 modulo 2^W, so 1023 wraps to 0. `done` is high for exactly that one cycle.
- R3: During an increment, `prog_ptr` keeps its old value for two cycles after acceptance. It then reads 0 for one cycle, because it is cleared before it is reloaded.
- R4: Register select codes are a=0, b=1, c=2, d=3, p=4, r=5, j=6 and t=7. For an absolute request (`addr_rel`=0), in the second cycle after acceptance, `mem_rd` is 1 and `mem_addr` equals the selected register.
- R5: For a relative request (`addr_rel`=1), `mem_addr` in that same cycle equals the selected register plus register j, modulo 2^W.
- R6: In the third cycle after acceptance of an address request, `mem_addr` is unchanged. In that cycle `mem_wdata` and `rd_data` both equal the `mem_rdata` word that was presented during the read cycle. `done` pulses one cycle later.
- R7: With 16 I/O words and 496 read-only words, the write-back asserts `mem_wr` only for addresses 0..15 and 512..1023. Addresses 16..511 give `mem_wr`=0.
- R8: While `busy` is 1, `start_inc`, `start_addr` and `reg_we` are ignored.
- R9: While idle, `reg_we` loads `reg_wdata` into register `reg_wsel`; writing code 4 sets `prog_ptr`. A start request in the same cycle as `reg_we` is ignored.
- R10: When `start_inc` and `start_addr` arrive together, only the increment runs, and `mem_rd` stays 0.
- R11: `mem_rd` and `mem_wr` are never high together. `mem_rd` lasts exactly one cycle and is followed by the write-back step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register load strobe (idle only) |
| reg_wsel | input | 3 | Register code for the load |
| reg_wdata | input | W | Value to load |
| start_inc | input | 1 | Request a program-pointer increment |
| start_addr | input | 1 | Request an address formation with read and write-back |
| addr_rel | input | 1 | 1 = add jump base, 0 = absolute |
| addr_sel | input | 3 | Register code supplying the address or offset |
| mem_rdata | input | W | Word returned by memory in the read cycle |
| mem_addr | output | W | Latched memory address during read and write-back |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write-back strobe |
| mem_wdata | output | W | Write-back data |
| rd_data | output | W | Last word read from memory |
| prog_ptr | output | W | Program pointer register |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The increment is run from every one of the 1024 pointer values. This separates a correct wrap at 1023 from a carry fault, and it catches a missing clear step on every path. Absolute addressing through register d is swept over all 1024 addresses with a distinct read word for each address. That sweep locates both edges of the read-only window exactly and shows that the written-back word is the one that was read. Absolute and relative forms are also tried for every select code with several jump bases, including sums that overflow. These runs tell the data registers, which pass through the ALU's OR path, apart from the address-bus registers. They also tell the shortcut routing apart from the input-switch routing. Collision patterns cover both starts at once, writes and starts at once, and writes or starts while busy, and they show that the losing request leaves no trace at the ports.

// File: rtl/swbus_pkg.sv
package swbus_pkg;

   localparam int NUM_REGS = 8;
   localparam int RSEL_W   = 3;

   localparam logic [RSEL_W-1:0] RG_A = 3'd0;
   localparam logic [RSEL_W-1:0] RG_B = 3'd1;
   localparam logic [RSEL_W-1:0] RG_C = 3'd2;
   localparam logic [RSEL_W-1:0] RG_D = 3'd3;
   localparam logic [RSEL_W-1:0] RG_P = 3'd4;
   localparam logic [RSEL_W-1:0] RG_R = 3'd5;
   localparam logic [RSEL_W-1:0] RG_J = 3'd6;
   localparam logic [RSEL_W-1:0] RG_T = 3'd7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_INC_ROUTE,
      ST_INC_CLEAR,
      ST_INC_LOAD,
      ST_ADR_FORM,
      ST_ADR_READ,
      ST_ADR_RESTORE
   } step_e;

   typedef enum logic [1:0] {
      ALU_OR,
      ALU_ADD,
      ALU_INC
   } alu_op_e;

   typedef struct packed {
      logic    in_alu;     // input switch: address bus to ALU instead of memory
      logic    out_mem;    // output switch: ALU to memory instead of data bus
      logic    shortcut;   // data bus joined to ALU input X
      logic    use_jbase;  // jump base on ALU input Y
      alu_op_e op;
   } sw_ctl_t;

endpackage

// File: rtl/swbus_regfile.sv
module swbus_regfile
   import swbus_pkg::*;
#(
   parameter int W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [RSEL_W-1:0] wr_sel,
   input  logic [W-1:0]      wr_data,
   input  logic              p_clear,
   input  logic              p_load,
   input  logic [W-1:0]      p_data,
   input  logic [RSEL_W-1:0] rd_sel,
   output logic [W-1:0]      rd_val,
   output logic [W-1:0]      p_q,
   output logic [W-1:0]      j_q
);

   logic [W-1:0] regs [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic [W-1:0] q;
      if (i == int'(RG_P)) begin : g_ptr
         always_ff @(posedge clk) begin
            if (!rst_n)                             q <= '0;
            else if (p_clear)                       q <= '0;
            else if (p_load)                        q <= p_data;
            else if (wr_en && wr_sel == RSEL_W'(i)) q <= wr_data;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (!rst_n)                             q <= '0;
            else if (wr_en && wr_sel == RSEL_W'(i)) q <= wr_data;
         end
      end
      assign regs[i] = q;
   end

   assign rd_val = regs[rd_sel];
   assign p_q    = regs[RG_P];
   assign j_q    = regs[RG_J];

endmodule

// File: rtl/swbus_alu.sv
module swbus_alu
   import swbus_pkg::*;
#(
   parameter int W = 10
) (
   input  alu_op_e      op,
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] res
);

   always_comb begin
      case (op)
         ALU_ADD: res = x + y;
         ALU_INC: res = x + W'(1);
         default: res = x | y;
      endcase
   end

endmodule

// File: rtl/swbus_steer.sv
module swbus_steer
   import swbus_pkg::*;
#(
   parameter int W = 10
) (
   input  sw_ctl_t      sw,
   input  logic         rd_is_data,
   input  logic         latch_to_dbus,
   input  logic [W-1:0] rd_val,
   input  logic [W-1:0] alu_latch,
   input  logic [W-1:0] jbase,
   input  logic [W-1:0] alu_res,
   output logic [W-1:0] alu_x,
   output logic [W-1:0] alu_y,
   output logic [W-1:0] dbus,
   output logic [W-1:0] addr_to_mem
);

   logic [W-1:0] abus;

   // data registers sit on the data bus, pointer-like registers on the address bus
   assign abus = rd_is_data ? '0 : rd_val;

   always_comb begin
      if (latch_to_dbus)   dbus = alu_latch;
      else if (rd_is_data) dbus = rd_val;
      else                 dbus = '0;
   end

   always_comb begin
      if (sw.shortcut)    alu_x = dbus;
      else if (sw.in_alu) alu_x = abus;
      else                alu_x = '0;
   end

   assign alu_y       = sw.use_jbase ? jbase : '0;
   assign addr_to_mem = sw.out_mem ? alu_res : abus;

endmodule

// File: rtl/swbus_ctrl.sv
module swbus_ctrl
   import swbus_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_inc,
   input  logic              start_addr,
   input  logic              addr_rel,
   input  logic [RSEL_W-1:0] addr_sel,
   input  logic              reg_we,
   output step_e             step,
   output sw_ctl_t           sw,
   output logic [RSEL_W-1:0] rd_sel,
   output logic              rd_is_data,
   output logic              wr_ok,
   output logic              done
);

   step_e             step_q, step_d;
   logic [RSEL_W-1:0] sel_q;
   logic              rel_q;
   logic              idle;

   assign idle  = (step_q == ST_IDLE);
   assign wr_ok = idle && reg_we;

   always_comb begin
      step_d = step_q;
      case (step_q)
         ST_IDLE: begin
            if (!reg_we && start_inc)       step_d = ST_INC_ROUTE;
            else if (!reg_we && start_addr) step_d = ST_ADR_FORM;
         end
         ST_INC_ROUTE: step_d = ST_INC_CLEAR;
         ST_INC_CLEAR: step_d = ST_INC_LOAD;
         ST_ADR_FORM:  step_d = ST_ADR_READ;
         ST_ADR_READ:  step_d = ST_ADR_RESTORE;
         default:      step_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q <= ST_IDLE;
         sel_q  <= '0;
         rel_q  <= 1'b0;
         done   <= 1'b0;
      end else begin
         step_q <= step_d;
         done   <= (step_q == ST_INC_LOAD) || (step_q == ST_ADR_RESTORE);
         if (idle && !reg_we && !start_inc && start_addr) begin
            sel_q <= addr_sel;
            rel_q <= addr_rel;
         end
      end
   end

   assign step       = step_q;
   assign rd_sel     = (step_q == ST_INC_ROUTE) ? RG_P : sel_q;
   assign rd_is_data = (rd_sel <= RG_C);

   always_comb begin
      sw = '{in_alu: 1'b0, out_mem: 1'b0, shortcut: 1'b0, use_jbase: 1'b0, op: ALU_OR};
      if (step_q == ST_INC_ROUTE) begin
         sw.in_alu = 1'b1;
         sw.op     = ALU_INC;
      end else if (step_q == ST_ADR_FORM) begin
         sw.shortcut = rd_is_data;
         if (rel_q) begin
            sw.in_alu    = !rd_is_data;
            sw.use_jbase = 1'b1;
            sw.out_mem   = 1'b1;
            sw.op        = ALU_ADD;
         end else begin
            sw.out_mem = rd_is_data;  // data registers pass via OR with Y = 0
         end
      end
   end

endmodule

// File: rtl/swbus_addr_path.sv
module swbus_addr_path
   import swbus_pkg::*;
#(
   parameter int W         = 10,
   parameter int IO_WORDS  = 16,
   parameter int ROM_WORDS = 496
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_wsel,
   input  logic [W-1:0]  reg_wdata,
   input  logic          start_inc,
   input  logic          start_addr,
   input  logic          addr_rel,
   input  logic [2:0]    addr_sel,
   input  logic [W-1:0]  mem_rdata,
   output logic [W-1:0]  mem_addr,
   output logic          mem_rd,
   output logic          mem_wr,
   output logic [W-1:0]  mem_wdata,
   output logic [W-1:0]  rd_data,
   output logic [W-1:0]  prog_ptr,
   output logic          busy,
   output logic          done
);

   localparam int           SPACE  = 1 << W;
   localparam logic [W-1:0] ROM_LO = W'(IO_WORDS);
   localparam logic [W-1:0] ROM_HI = W'(IO_WORDS + ROM_WORDS - 1);

   if (W < 4 || W > 16) begin : g_bad_width
      $error("swbus_addr_path: W must lie in 4..16");
   end
   if (IO_WORDS < 1 || ROM_WORDS < 1 || IO_WORDS + ROM_WORDS >= SPACE) begin : g_bad_map
      $error("swbus_addr_path: I/O plus read-only region must leave writable space");
   end

   step_e             step;
   sw_ctl_t           sw;
   logic [RSEL_W-1:0] rd_sel;
   logic              rd_is_data, wr_ok;
   logic [W-1:0]      rd_val, p_q, j_q;
   logic [W-1:0]      alu_x, alu_y, alu_res, dbus, addr_to_mem;
   logic [W-1:0]      alu_latch_q, addr_latch_q, mbuf_q;
   logic              in_rom;

   swbus_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_inc  (start_inc),
      .start_addr (start_addr),
      .addr_rel   (addr_rel),
      .addr_sel   (addr_sel),
      .reg_we     (reg_we),
      .step       (step),
      .sw         (sw),
      .rd_sel     (rd_sel),
      .rd_is_data (rd_is_data),
      .wr_ok      (wr_ok),
      .done       (done)
   );

   swbus_regfile #(.W(W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_ok),
      .wr_sel  (reg_wsel),
      .wr_data (reg_wdata),
      .p_clear (step == ST_INC_CLEAR),
      .p_load  (step == ST_INC_LOAD),
      .p_data  (dbus),
      .rd_sel  (rd_sel),
      .rd_val  (rd_val),
      .p_q     (p_q),
      .j_q     (j_q)
   );

   swbus_steer #(.W(W)) u_steer (
      .sw            (sw),
      .rd_is_data    (rd_is_data),
      .latch_to_dbus (step == ST_INC_LOAD),
      .rd_val        (rd_val),
      .alu_latch     (alu_latch_q),
      .jbase         (j_q),
      .alu_res       (alu_res),
      .alu_x         (alu_x),
      .alu_y         (alu_y),
      .dbus          (dbus),
      .addr_to_mem   (addr_to_mem)
   );

   swbus_alu #(.W(W)) u_alu (
      .op  (sw.op),
      .x   (alu_x),
      .y   (alu_y),
      .res (alu_res)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alu_latch_q  <= '0;
         addr_latch_q <= '0;
         mbuf_q       <= '0;
      end else begin
         if (step == ST_INC_ROUTE) alu_latch_q  <= alu_res;
         if (step == ST_ADR_FORM)  addr_latch_q <= addr_to_mem;
         if (step == ST_ADR_READ)  mbuf_q       <= mem_rdata;
      end
   end

   assign in_rom    = (addr_latch_q >= ROM_LO) && (addr_latch_q <= ROM_HI);
   assign mem_rd    = (step == ST_ADR_READ);
   assign mem_wr    = (step == ST_ADR_RESTORE) && !in_rom;
   assign mem_addr  = (mem_rd || step == ST_ADR_RESTORE) ? addr_latch_q : '0;
   assign mem_wdata = (step == ST_ADR_RESTORE) ? mbuf_q : '0;
   assign rd_data   = mbuf_q;
   assign prog_ptr  = p_q;
   assign busy      = (step != ST_IDLE);

endmodule

// File: rtl/swbus_addr_path_chk.sv
module swbus_addr_path_chk #(
   parameter int W         = 10,
   parameter int IO_WORDS  = 16,
   parameter int ROM_WORDS = 496
) (
   input logic         clk,
   input logic         rst_n,
   input logic         mem_rd,
   input logic         mem_wr,
   input logic [W-1:0] mem_addr,
   input logic [W-1:0] mem_wdata,
   input logic [W-1:0] mem_rdata,
   input logic         busy,
   input logic         done
);

   localparam logic [W-1:0] LO = W'(IO_WORDS);
   localparam logic [W-1:0] HI = W'(IO_WORDS + ROM_WORDS - 1);

   // R11
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R11
   rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> (!mem_rd && busy));

   // R7
   rom_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> !(mem_addr >= LO && mem_addr <= HI));

   // R6
   wb_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($past(mem_rd) && mem_addr == $past(mem_addr)));

   // R6
   wb_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (mem_wdata == $past(mem_rdata)));

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

bind swbus_addr_path swbus_addr_path_chk #(
   .W(W), .IO_WORDS(IO_WORDS), .ROM_WORDS(ROM_WORDS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_rd    (mem_rd),
   .mem_wr    (mem_wr),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_rdata (mem_rdata),
   .busy      (busy),
   .done      (done)
);

// File: tb/swbus_addr_path_test.sv
`timescale 1ns/1ps
module swbus_addr_path_test;

   localparam int W = 10;
   localparam int M = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_we = 1'b0;
   logic [2:0]   reg_wsel = '0;
   logic [W-1:0] reg_wdata = '0;
   logic         start_inc = 1'b0, start_addr = 1'b0, addr_rel = 1'b0;
   logic [2:0]   addr_sel = '0;
   logic [W-1:0] mem_rdata = '0;
   logic [W-1:0] mem_addr, mem_wdata, rd_data, prog_ptr;
   logic         mem_rd, mem_wr, busy, done;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int model [8];

   always #2 clk = ~clk;

   swbus_addr_path #(.W(W), .IO_WORDS(16), .ROM_WORDS(496)) uut (.*);

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input int sel, input int val);
      reg_we = 1'b1; reg_wsel = 3'(sel); reg_wdata = W'(val);
      tick();
      reg_we = 1'b0;
      model[sel] = val % M;
   endtask

   function automatic int writable(input int a);
      return (a < 16 || a > 511) ? 1 : 0;
   endfunction

   // increment; also_addr raises start_addr in the same cycle (R10)
   task automatic do_inc(input bit also_addr);
      int old;
      old = model[4];
      start_inc = 1'b1; start_addr = also_addr;
      tick();
      start_inc = 1'b0; start_addr = 1'b0;
      chk("R2 busy after accept", busy, 1);
      chk("R3 ptr held step1", prog_ptr, old);
      chk("R10 no read during inc", mem_rd, 0);
      tick();
      chk("R3 ptr held step2", prog_ptr, old);
      chk("R10 no read during inc", mem_rd, 0);
      tick();
      chk("R3 ptr cleared", prog_ptr, 0);
      chk("R10 no read during inc", mem_rd, 0);
      tick();
      model[4] = (old + 1) % M;
      chk("R2 ptr incremented", prog_ptr, model[4]);
      chk("R2 done high", done, 1);
      tick();
      chk("R2 done one cycle", done, 0);
      chk("R10 idle after inc", busy, 0);
   endtask

   task automatic do_addr(input int sel, input bit rel, input int rdv);
      int ea;
      ea = rel ? (model[sel] + model[6]) % M : model[sel];
      start_addr = 1'b1; addr_rel = rel; addr_sel = 3'(sel);
      tick();
      start_addr = 1'b0;
      chk("R11 no read in form step", mem_rd, 0);
      tick();
      chk("R11 read strobe", mem_rd, 1);
      if (rel) chk("R5 relative address", mem_addr, ea);
      else     chk("R4 absolute address", mem_addr, ea);
      mem_rdata = W'(rdv);
      tick();
      mem_rdata = '0;
      chk("R11 read one cycle", mem_rd, 0);
      chk("R6 write-back address", mem_addr, ea);
      chk("R7 write-back enable", mem_wr, writable(ea));
      chk("R6 write-back data", mem_wdata, rdv % M);
      chk("R6 read data", rd_data, rdv % M);
      tick();
      chk("R6 done after write-back", done, 1);
      chk("R6 idle", busy, 0);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) model[i] = 0;
      tick(); tick();
      chk("R1 reset ptr", prog_ptr, 0);
      chk("R1 reset busy", busy, 0);
      chk("R1 reset done", done, 0);
      chk("R1 reset strobes", mem_rd + mem_wr, 0);
      rst_n = 1'b1;
      tick();
      chk("R1 after reset ptr", prog_ptr, 0);
      chk("R1 after reset busy", busy, 0);

      // R2 R3: every pointer value, including the wrap at 1023
      for (int v = 0; v < M; v++) begin
         wr(4, v);
         chk("R9 ptr load", prog_ptr, v);
         do_inc(1'b0);
      end

      // R4 R7 R6: every address through register d
      for (int v = 0; v < M; v++) begin
         wr(3, v);
         do_addr(3, 1'b0, (v * 37 + 11) % M);
      end

      // R4 R5: every select code, absolute and relative, several bases
      for (int b = 0; b < 4; b++) begin
         int jb;
         jb = (b == 0) ? 0 : (b == 1) ? 1 : (b == 2) ? 500 : 1000;
         for (int s = 0; s < 8; s++) wr(s, (s * 131 + b * 77 + 5) % M);
         wr(6, jb);
         for (int s = 0; s < 8; s++) begin
            do_addr(s, 1'b0, s + 3);
            do_addr(s, 1'b1, s + 900);
         end
      end

      // R10: both starts together; increment only, wraps 1023 to 0
      wr(4, 1023);
      do_inc(1'b1);
      chk("R10 ptr wrapped", prog_ptr, 0);

      // R9: write and start in the same idle cycle
      reg_we = 1'b1; reg_wsel = 3'd4; reg_wdata = 10'd33; start_inc = 1'b1;
      tick();
      reg_we = 1'b0; start_inc = 1'b0; model[4] = 33;
      chk("R9 start ignored with write", busy, 0);
      chk("R9 write applied", prog_ptr, 33);
      tick();
      chk("R9 ptr stays", prog_ptr, 33);
      chk("R9 no done", done, 0);

      // R8: requests and writes during a sequence are ignored
      for (int pass = 0; pass < 2; pass++) begin
         int old, tv;
         old = model[4];
         tv = model[7];
         start_inc = 1'b1;
         tick();
         start_inc = 1'b0;
         start_addr = 1'b1; addr_sel = 3'd7; reg_we = 1'b1;
         reg_wsel = (pass == 0) ? 3'd4 : 3'd7; reg_wdata = 10'd777;
         tick();
         start_addr = 1'b0; reg_we = 1'b0;
         chk("R8 ptr unchanged by write", prog_ptr, old);
         tick();
         chk("R8 ptr cleared", prog_ptr, 0);
         tick();
         chk("R8 ptr incremented", prog_ptr, (old + 1) % M);
         chk("R8 done", done, 1);
         tick();
         chk("R8 no extra sequence", busy, 0);
         chk("R8 no read", mem_rd, 0);
         model[4] = (old + 1) % M;
         chk("R8 t unchanged", model[7], tv);
         do_addr(7, 1'b0, 12);
      end

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule